// File: doc/BRIEF.md
# Cross-Clock One-Word Bypass Mailbox

This block provides two single-word message slots between a controlling port A, clocked by `clk_a`, and a second port B, clocked by `clk_b`. One slot carries words from A to B and the other from B to A. A word passes straight from the writer's capture register to the reader's output register. Each slot behaves as a one-deep queue, and a full/available handshake on each side says when a word may be written and when one is waiting.

Port A alone decides when the mailboxes are in use. It turns bypass mode on by selecting the block (`a_cs` high) and presenting address code 3'b001. It turns the mode off with code 3'b000 or by dropping `a_cs`. Port B learns the mode from `b_bypass`, which comes through a two-flop synchronizer. Every handshake event that crosses a clock boundary is a level toggle carried by a two-flop synchronizer. After the mode ends, port B gets exactly one more clock-B cycle to collect a pending word. After that, any word still in either slot is discarded, and the handshake returns to idle for the next session.

Top module: `bypass_mailbox`

## Requirements
- R1: While `rst` is high, and after its release until the first transfer, `ab_full`, `ab_avail`, `ba_full`, `ba_avail` and `b_bypass` are low, and `a_rdata` and `b_rdata` are zero.
- R2: Port A enters bypass mode on the `clk_a` edge where `a_cs`=1 and `a_addr`=3'b001. It leaves the mode on the edge where `a_cs`=0 or `a_addr`=3'b000. Any other address code leaves the mode unchanged. `b_bypass` follows the mode within three `clk_b` edges.
- R3: A port-A write needs `a_cs`=1, `a_addr`=3'b001, `a_en`=1, `a_wr`=1, bypass mode already active and `ab_full`=0. It captures `a_wdata` and raises `ab_full` on that edge. A write attempted while `ab_full`=1 is ignored.
- R4: `ab_avail` rises within three `clk_b` edges after an accepted port-A write.
- R5: A port-B read needs `b_en`=1, `b_wr`=0 and `ab_avail`=1. While the read is permitted, it loads the word into `b_rdata` and clears `ab_avail` on that `clk_b` edge, and `ab_full` falls within three `clk_a` edges.
- R6: B to A mirrors this handshake. A port-B write needs `b_en`=1, `b_wr`=1, `b_bypass`=1 and `ba_full`=0, and it raises `ba_full`. `ba_avail` rises within three `clk_a` edges. A port-A read (`a_cs`=1, `a_addr`=3'b001, `a_en`=1, `a_wr`=0, mode active) loads `a_rdata` and clears `ba_avail`.
- R7: `a_rdata` and `b_rdata` change only on an accepted read. A pending word stays available while its reader is idle.
- R8: A port-B read is still permitted on the first `clk_b` edge after `b_bypass` falls. If port B does not read on that edge, the pending A-to-B word is discarded on the next edge: `ab_avail` clears, `b_rdata` is kept, and `ab_full` later falls.
- R9: Once port A has left bypass mode, a pending B-to-A word is discarded on the following `clk_a` edge: `ba_avail` clears, `a_rdata` is kept, and `ba_full` later falls.
- R10: Both directions operate at the same time. Port A and port B can each read a word on their own clocks in the same interval.
- R11: Words written in sequence arrive in order, each exactly once, with no loss or duplication, while both sides follow the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| a_cs | input | 1 | Port A select, active high |
| a_addr | input | 3 | Port A resource code (3'b001 bypass, 3'b000 queue mode) |
| a_en | input | 1 | Port A transfer enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_wdata | input | DATA_W | Word written by port A |
| a_rdata | output | DATA_W | Port A output register |
| ab_full | output | 1 | A-to-B slot holds an unconsumed word (clk_a domain) |
| ba_avail | output | 1 | B-to-A word waiting for port A (clk_a domain) |
| b_en | input | 1 | Port B transfer enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_wdata | input | DATA_W | Word written by port B |
| b_rdata | output | DATA_W | Port B output register |
| b_bypass | output | 1 | Bypass mode seen in clk_b domain |
| ab_avail | output | 1 | A-to-B word waiting for port B (clk_b domain) |
| ba_full | output | 1 | B-to-A slot holds an unconsumed word (clk_b domain) |

## Verification
Each slot's state is a pair of toggle bits, one per domain. A stuck or duplicated toggle shows up within a few cycles of either clock. Either a `*_full` flag never drops, or an `*_avail` flag reasserts with no new write, and the next word then arrives twice or never. A faulty exit window appears on the first `clk_b` edge after `b_bypass` falls: a word is lost that port B tried to read, or a word survives that should have been flushed. An error in the capture register appears directly as a wrong value in `a_rdata` or `b_rdata` on the read edge.

// File: rtl/bypass_mailbox_pkg.sv
`timescale 1ns/1ps
package bypass_mailbox_pkg;
  typedef logic [2:0] port_code_t;
  localparam port_code_t CODE_QUEUE  = 3'b000;
  localparam port_code_t CODE_BYPASS = 3'b001;
endpackage

// File: rtl/bmb_sync.sv
`timescale 1ns/1ps
module bmb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bmb_mode.sv
`timescale 1ns/1ps
module bmb_mode
  import bypass_mailbox_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk_a,
  input  logic       clk_b,
  input  logic       rst,
  input  logic       a_cs,
  input  port_code_t a_addr,
  output logic       mode_a,
  output logic       mode_b,
  output logic       b_rd_allow
);
  logic mode_b_d;

  // port A owns the mode; unlisted codes hold it
  always_ff @(posedge clk_a) begin
    if (rst)                                  mode_a <= 1'b0;
    else if (!a_cs || a_addr == CODE_QUEUE)   mode_a <= 1'b0;
    else if (a_addr == CODE_BYPASS)           mode_a <= 1'b1;
  end

  bmb_sync #(.STAGES(STAGES)) u_mode_sync (
    .clk(clk_b), .rst(rst), .d(mode_a), .q(mode_b)
  );

  always_ff @(posedge clk_b) begin
    if (rst) mode_b_d <= 1'b0;
    else     mode_b_d <= mode_b;
  end

  // one extra clk_b cycle of read permission after the mode drops
  assign b_rd_allow = mode_b | mode_b_d;
endmodule

// File: rtl/bmb_slot.sv
`timescale 1ns/1ps
module bmb_slot #(
  parameter int W      = 18,
  parameter int STAGES = 2
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rd_req,
  input  logic         rd_allow,
  output logic         avail,
  output logic [W-1:0] rdata
);
  logic         wtog, rtog, wtog_r, rtog_w;
  logic [W-1:0] hold;
  logic         wr_fire, rd_fire, drop;

  // writer side: capture register and request toggle
  assign full    = wtog ^ rtog_w;
  assign wr_fire = wr_req & ~full;

  always_ff @(posedge wclk) begin
    if (rst) begin
      wtog <= 1'b0;
      hold <= '0;
    end else if (wr_fire) begin
      wtog <= ~wtog;
      hold <= wdata;
    end
  end

  bmb_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(rclk), .rst(rst), .d(wtog), .q(wtog_r)
  );

  // reader side: acknowledge toggle and output register
  assign avail   = wtog_r ^ rtog;
  assign rd_fire = rd_req & rd_allow & avail;
  assign drop    = ~rd_allow & avail;

  always_ff @(posedge rclk) begin
    if (rst) begin
      rtog  <= 1'b0;
      rdata <= '0;
    end else begin
      if (rd_fire || drop) rtog  <= ~rtog;
      if (rd_fire)         rdata <= hold;
    end
  end

  bmb_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(wclk), .rst(rst), .d(rtog), .q(rtog_w)
  );
endmodule

// File: rtl/bypass_mailbox.sv
`timescale 1ns/1ps
module bypass_mailbox
  import bypass_mailbox_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst,
  input  logic              a_cs,
  input  logic [2:0]        a_addr,
  input  logic              a_en,
  input  logic              a_wr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              ab_full,
  output logic              ba_avail,
  input  logic              b_en,
  input  logic              b_wr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_bypass,
  output logic              ab_avail,
  output logic              ba_full
);
  logic mode_a, b_rd_allow;
  logic a_sel, a_wr_req, a_rd_req, b_wr_req, b_rd_req;

  bmb_mode #(.STAGES(SYNC_STAGES)) u_mode (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
    .a_cs(a_cs), .a_addr(a_addr),
    .mode_a(mode_a), .mode_b(b_bypass), .b_rd_allow(b_rd_allow)
  );

  assign a_sel    = a_cs & (a_addr == CODE_BYPASS) & mode_a;
  assign a_wr_req = a_sel & a_en & a_wr;
  assign a_rd_req = a_sel & a_en & ~a_wr;
  assign b_wr_req = b_bypass & b_en & b_wr;
  assign b_rd_req = b_en & ~b_wr;

  bmb_slot #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_ab (
    .wclk(clk_a), .rclk(clk_b), .rst(rst),
    .wr_req(a_wr_req), .wdata(a_wdata), .full(ab_full),
    .rd_req(b_rd_req), .rd_allow(b_rd_allow),
    .avail(ab_avail), .rdata(b_rdata)
  );

  bmb_slot #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_ba (
    .wclk(clk_b), .rclk(clk_a), .rst(rst),
    .wr_req(b_wr_req), .wdata(b_wdata), .full(ba_full),
    .rd_req(a_rd_req), .rd_allow(mode_a),
    .avail(ba_avail), .rdata(a_rdata)
  );
endmodule

// File: rtl/bypass_mailbox_chk.sv
`timescale 1ns/1ps
module bypass_mailbox_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst,
  input logic              a_cs,
  input logic [2:0]        a_addr,
  input logic              a_en,
  input logic              a_wr,
  input logic [DATA_W-1:0] a_rdata,
  input logic              ab_full,
  input logic              ba_avail,
  input logic              b_en,
  input logic              b_wr,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_bypass,
  input logic              ab_avail,
  input logic              ba_full
);
  // R3
  ab_full_needs_write_chk: assert property (@(posedge clk_a) disable iff (rst)
    (!ab_full && !(a_cs && a_addr == 3'b001 && a_en && a_wr)) |=> !ab_full);

  // R6
  ba_full_needs_write_chk: assert property (@(posedge clk_b) disable iff (rst)
    (!ba_full && !(b_en && b_wr && b_bypass)) |=> !ba_full);

  // R5
  b_read_consumes_chk: assert property (@(posedge clk_b) disable iff (rst)
    (b_bypass && b_en && !b_wr && ab_avail) |=> !ab_avail);

  // R7
  a_rdata_hold_chk: assert property (@(posedge clk_a) disable iff (rst)
    !(a_cs && a_addr == 3'b001 && a_en && !a_wr) |=> $stable(a_rdata));

  // R7
  b_rdata_hold_chk: assert property (@(posedge clk_b) disable iff (rst)
    !(b_en && !b_wr) |=> $stable(b_rdata));

  // R8
  ab_flush_after_window_chk: assert property (@(posedge clk_b) disable iff (rst)
    (!b_bypass && !$past(b_bypass) && ab_avail) |=> !ab_avail);

  // R9
  ba_flush_on_exit_chk: assert property (@(posedge clk_a) disable iff (rst)
    (!a_cs && $past(!a_cs) && ba_avail) |=> !ba_avail);
endmodule

bind bypass_mailbox bypass_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
  .a_cs(a_cs), .a_addr(a_addr), .a_en(a_en), .a_wr(a_wr),
  .a_rdata(a_rdata), .ab_full(ab_full), .ba_avail(ba_avail),
  .b_en(b_en), .b_wr(b_wr), .b_rdata(b_rdata),
  .b_bypass(b_bypass), .ab_avail(ab_avail), .ba_full(ba_full)
);

// File: tb/sim_bypass_mailbox.sv
`timescale 1ns/1ps
module sim_bypass_mailbox;
  localparam int W = 18;

  logic clk_a = 1'b0, clk_b = 1'b0, rst = 1'b1;
  logic a_cs = 1'b0, a_en = 1'b0, a_wr = 1'b0;
  logic [2:0] a_addr = 3'b000;
  logic [W-1:0] a_wdata = '0, b_wdata = '0;
  logic b_en = 1'b0, b_wr = 1'b0;
  logic [W-1:0] a_rdata, b_rdata;
  logic ab_full, ba_avail, b_bypass, ab_avail, ba_full;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk_a = ~clk_a;
  always #7 clk_b = ~clk_b;

  bypass_mailbox #(.DATA_W(W)) u0 (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
    .a_cs(a_cs), .a_addr(a_addr), .a_en(a_en), .a_wr(a_wr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .ab_full(ab_full), .ba_avail(ba_avail),
    .b_en(b_en), .b_wr(b_wr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .b_bypass(b_bypass), .ab_avail(ab_avail), .ba_full(ba_full)
  );

  // bit 18: 0 = A to B, 1 = B to A
  localparam logic [W:0] VEC [0:7] = '{
    19'h0_0001, 19'h4_2AAA, 19'h3_FFFF, 19'h0_1555,
    19'h4_0000, 19'h3_8001, 19'h7_3C3C, 19'h0_0F0F
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic cur(input int sel);
    case (sel)
      0: cur = ab_avail;
      1: cur = b_bypass;
      2: cur = ba_avail;
      3: cur = !ab_full;
      4: cur = !ba_full;
      default: cur = !b_bypass;
    endcase
  endfunction

  // wait (sampling at negedges of the signal's own clock) until selector is true
  task automatic wait_for(input int sel, input int maxc, input string req);
    bit ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      if (sel == 2 || sel == 3) @(negedge clk_a); else @(negedge clk_b);
      if (cur(sel)) begin ok = 1'b1; break; end
    end
    chk({31'd0, ok}, 32'd1, req);
  endtask

  task automatic a_write(input logic [W-1:0] d);
    @(negedge clk_a); a_en = 1'b1; a_wr = 1'b1; a_wdata = d;
    @(negedge clk_a); a_en = 1'b0; a_wr = 1'b0;
  endtask

  task automatic a_read();
    @(negedge clk_a); a_en = 1'b1; a_wr = 1'b0;
    @(negedge clk_a); a_en = 1'b0;
  endtask

  task automatic b_write(input logic [W-1:0] d);
    @(negedge clk_b); b_en = 1'b1; b_wr = 1'b1; b_wdata = d;
    @(negedge clk_b); b_en = 1'b0; b_wr = 1'b0;
  endtask

  task automatic b_read();
    @(negedge clk_b); b_en = 1'b1; b_wr = 1'b0;
    @(negedge clk_b); b_en = 1'b0;
  endtask

  task automatic enter_bypass();
    @(negedge clk_a); a_cs = 1'b1; a_addr = 3'b001;
    wait_for(1, 4, "R2 enter");
  endtask

  initial begin
    logic [W-1:0] last_b;
    logic [W-1:0] last_a;
    // R1 reset state
    repeat (6) @(negedge clk_b);
    chk({27'd0, ab_full, ab_avail, ba_full, ba_avail, b_bypass}, 32'd0, "R1 flags in reset");
    @(negedge clk_a); rst = 1'b0;
    repeat (3) @(negedge clk_b);
    chk({27'd0, ab_full, ab_avail, ba_full, ba_avail, b_bypass}, 32'd0, "R1 flags after reset");
    chk({14'd0, a_rdata}, 32'd0, "R1 a_rdata");
    chk({14'd0, b_rdata}, 32'd0, "R1 b_rdata");

    enter_bypass();

    // table walk: R3 R4 R5 R6 R11
    for (int v = 0; v < 8; v++) begin
      if (!VEC[v][W]) begin
        a_write(VEC[v][W-1:0]);
        chk({31'd0, ab_full}, 32'd1, "R3 full after write");
        wait_for(0, 4, "R4 avail at B");
        b_read();
        chk({14'd0, b_rdata}, {14'd0, VEC[v][W-1:0]}, "R11 A to B word");
        chk({31'd0, ab_avail}, 32'd0, "R5 avail cleared");
        wait_for(3, 4, "R5 full released");
      end else begin
        b_write(VEC[v][W-1:0]);
        chk({31'd0, ba_full}, 32'd1, "R6 full after write");
        wait_for(2, 4, "R6 avail at A");
        a_read();
        chk({14'd0, a_rdata}, {14'd0, VEC[v][W-1:0]}, "R11 B to A word");
        chk({31'd0, ba_avail}, 32'd0, "R6 avail cleared");
        wait_for(4, 4, "R6 full released");
      end
    end

    // R3 write while full is ignored
    a_write(18'h11111);
    a_write(18'h22222);
    wait_for(0, 4, "R3 first word avail");
    b_read();
    chk({14'd0, b_rdata}, 32'h11111, "R3 first word kept");
    wait_for(3, 4, "R3 full released");
    repeat (5) @(negedge clk_b);
    chk({31'd0, ab_avail}, 32'd0, "R3 blocked word absent");

    // R7 idle reader keeps word and output
    last_b = b_rdata;
    a_write(18'h0ABCD);
    wait_for(0, 4, "R7 avail");
    repeat (4) @(negedge clk_b);
    chk({31'd0, ab_avail}, 32'd1, "R7 word waits");
    chk({14'd0, b_rdata}, {14'd0, last_b}, "R7 b_rdata held");
    b_read();
    chk({14'd0, b_rdata}, 32'h0ABCD, "R7 delayed read");
    wait_for(3, 4, "R7 full released");

    // R10 both directions at once
    fork
      a_write(18'h13579);
      b_write(18'h2468A);
    join
    wait_for(0, 4, "R10 ab avail");
    wait_for(2, 4, "R10 ba avail");
    fork
      a_read();
      b_read();
    join
    chk({14'd0, b_rdata}, 32'h13579, "R10 B got word");
    chk({14'd0, a_rdata}, 32'h2468A, "R10 A got word");
    wait_for(3, 4, "R10 ab released");
    wait_for(4, 4, "R10 ba released");

    // R2 other code holds the mode
    @(negedge clk_a); a_addr = 3'b110;
    repeat (6) @(negedge clk_b);
    chk({31'd0, b_bypass}, 32'd1, "R2 hold on other code");
    @(negedge clk_a); a_addr = 3'b001;

    // R8 read in the exit window succeeds
    a_write(18'h3A5A5);
    wait_for(0, 4, "R8 avail");
    @(negedge clk_a); a_addr = 3'b000;
    wait_for(5, 5, "R2 exit on code 000");
    b_en = 1'b1; b_wr = 1'b0;
    @(negedge clk_b); b_en = 1'b0;
    chk({14'd0, b_rdata}, 32'h3A5A5, "R8 window read");
    wait_for(3, 4, "R8 full after window read");

    // R8 unread word is discarded after the window
    enter_bypass();
    a_write(18'h05A5A);
    wait_for(0, 4, "R8 second avail");
    @(negedge clk_a); a_addr = 3'b000;
    wait_for(5, 5, "R8 mode drop");
    repeat (3) @(negedge clk_b);
    chk({31'd0, ab_avail}, 32'd0, "R8 word discarded");
    chk({14'd0, b_rdata}, 32'h3A5A5, "R8 b_rdata kept");
    wait_for(3, 6, "R8 full released after discard");

    // R9 leaving the mode drops a pending B to A word
    enter_bypass();
    last_a = a_rdata;
    b_write(18'h1F00F);
    wait_for(2, 4, "R9 avail");
    @(negedge clk_a); a_cs = 1'b0;
    repeat (2) @(negedge clk_a);
    chk({31'd0, ba_avail}, 32'd0, "R9 word discarded");
    chk({14'd0, a_rdata}, {14'd0, last_a}, "R9 a_rdata kept");
    wait_for(5, 5, "R2 exit on deselect");
    wait_for(4, 6, "R9 full released");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule